// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital sequencer that sits in front of an 8-bit successive-approximation converter. It decides which analog channel is converted next. It issues a one-cycle start pulse to the converter, waits for the converter's done strobe, and stores the returned code in a bank of eight 8-bit result registers. The converter itself is seen only through this start/done/data handshake.

Three conversion modes are offered:

- **Single:** one chosen channel is converted once.
- **Continuous:** one chosen channel is converted again and again into a rotating result bank, until a stop command arrives.
- **Scan:** every channel named in an eight-bit mask is converted once, lowest index first.

A sticky completion flag is raised at the points each mode defines. It is cleared by a strobe and gated by an enable to form the interrupt output. A busy output covers the whole sequence.

Software reads any result register through a combinational read port.

Top module: `adc_mode_sequencer`

## Requirements
- R1: After reset, busy_o, irq_flag_o, irq_o and conv_start_o are low and all eight result registers read 0.
- R2: Mode code 0 (single): a start converts chan_i once, stores the code in the register of that channel, sets the flag and drops busy on the clock edge that samples conv_done_i.
- R3: Mode code 1 (continuous): results of chan_i go into registers 0,1,…,7 in that order, starting at register 0 on every start, then wrap to 0 and overwrite.
- R4: In continuous mode with split_i=1 the flag is set after every fourth conversion; with split_i=0 it is set after every eighth.
- R5: A stop_i pulse in continuous mode lets the conversion in flight finish and be stored, then returns to idle with no further start pulse; stop_i has no effect in the other modes.
- R6: Mode code 2 (scan): each channel whose bit is set in scan_mask_i (bit n = channel n) is converted exactly once, in ascending channel order, and its code goes into its own register.
- R7: In scan mode with split_i=1 the flag is set after the fourth conversion and again at the end of the scan; with four or fewer channels, or with split_i=0, it is set only at the end.
- R8: A scan start with an all-zero mask, or any start with mode code 3, starts no conversion and leaves busy low.
- R9: busy_o is high from the edge that accepts a start until the edge that ends the sequence; a start while busy is ignored.
- R10: irq_flag_o stays set until irq_clr_i; a set in the same cycle wins over a clear; irq_o equals irq_flag_o AND irq_en_i.
- R11: conv_start_o is a one-cycle pulse, carrying the channel on conv_chan_o, issued only while busy and only after the previous conversion's done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command (one cycle) |
| stop_i | input | 1 | Stop command for continuous mode |
| mode_i | input | 2 | 0 single, 1 continuous, 2 scan, 3 reserved |
| chan_i | input | 3 | Channel for single and continuous modes |
| scan_mask_i | input | 8 | Channel selection for scan mode |
| split_i | input | 1 | Raise the flag after groups of four |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Flag clear strobe |
| conv_start_o | output | 1 | Converter start pulse |
| conv_chan_o | output | 3 | Channel for the converter |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 8 | Converter result, valid with done |
| rd_addr_i | input | 3 | Result register read address |
| rd_data_o | output | 8 | Result register read data |
| busy_o | output | 1 | Sequence active |
| irq_flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, 8-bit results and a group size of four. With these values a continuous run of 17 conversions wraps the 3-bit write pointer twice. A five-channel mask crosses the group-of-four point before the scan ends, while a two-channel mask does not. A converter stub with a latency of two to four cycles moves the done strobe against the stop pulse and the clear strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_SCAN   = 2'd2,
        MODE_RSVD   = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]         src_i,
    output logic                   any_o,
    output logic [$clog2(NCH)-1:0] idx_o
);
    localparam int CW = $clog2(NCH);

    logic [NCH:0]   seen;
    logic [NCH-1:0] first_oh;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chain
            assign first_oh[g]  = src_i[g] & ~seen[g];
            assign seen[g + 1]  = seen[g] | src_i[g];
        end
    endgenerate

    assign any_o = seen[NCH];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (first_oh[i]) idx_o = idx_o | CW'(i);
        end
    end

endmodule

// File: rtl/adc_seq_resbank.sv
module adc_seq_resbank #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [$clog2(NCH)-1:0] wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    input  logic [$clog2(NCH)-1:0] rd_addr_i,
    output logic [DW-1:0]          rd_data_o
);
    logic [DW-1:0] bank_d [NCH];
    logic [DW-1:0] bank_q [NCH];

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) bank_d[wr_addr_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) bank_q[i] <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data_o = bank_q[rd_addr_i];

    // R3 / R6: a written code is held in the addressed register
    a_r3_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> bank_q[$past(wr_addr_i)] == $past(wr_data_i));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SPLIT_AT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic [1:0]             mode_i,
    input  logic [$clog2(NCH)-1:0] chan_i,
    input  logic [NCH-1:0]         mask_i,
    input  logic                   split_i,
    input  logic                   irq_clr_i,
    input  logic                   conv_done_i,
    input  logic                   pick_any_i,
    input  logic [$clog2(NCH)-1:0] pick_idx_i,
    output logic [NCH-1:0]         pick_src_o,
    output logic                   conv_start_o,
    output logic [$clog2(NCH)-1:0] conv_chan_o,
    output logic                   wr_en_o,
    output logic [$clog2(NCH)-1:0] wr_addr_o,
    output logic                   busy_o,
    output logic                   flag_o
);
    localparam int CW = $clog2(NCH);
    localparam int NW = CW + 1;
    localparam logic [CW-1:0] GRP_MASK = CW'(SPLIT_AT - 1);
    localparam logic [CW-1:0] LAST_PTR = CW'(NCH - 1);
    localparam logic [NW-1:0] GRP_CNT  = NW'(SPLIT_AT);

    typedef struct packed {
        seq_state_e     st;
        seq_mode_e      mode;
        logic [CW-1:0]  chan;
        logic [NCH-1:0] rem;
        logic           split;
        logic [CW-1:0]  ptr;
        logic [NW-1:0]  cnt;
        logic           stop;
        logic           flag;
    } ctrl_t;

    ctrl_t          r_d, r_q;
    logic           set_flag;
    logic           accept;
    logic           stop_req;
    logic [NCH-1:0] rem_clear;
    logic [NW-1:0]  cnt_next;

    assign rem_clear  = r_q.rem & ~(NCH'(1) << r_q.chan);
    assign pick_src_o = (r_q.st == ST_IDLE) ? mask_i : rem_clear;
    assign cnt_next   = r_q.cnt + NW'(1);
    assign stop_req   = r_q.stop | (stop_i && r_q.mode == MODE_CONT);

    always_comb begin
        r_d       = r_q;
        set_flag  = 1'b0;
        accept    = 1'b0;
        wr_en_o   = 1'b0;
        wr_addr_o = r_q.chan;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    case (seq_mode_e'(mode_i))
                        MODE_SINGLE, MODE_CONT: begin
                            accept   = 1'b1;
                            r_d.chan = chan_i;
                        end
                        MODE_SCAN: begin
                            if (pick_any_i) begin
                                accept   = 1'b1;
                                r_d.chan = pick_idx_i;
                                r_d.rem  = mask_i;
                            end
                        end
                        default: accept = 1'b0;
                    endcase
                end
                if (accept) begin
                    r_d.st    = ST_ISSUE;
                    r_d.mode  = seq_mode_e'(mode_i);
                    r_d.split = split_i;
                    r_d.ptr   = '0;
                    r_d.cnt   = '0;
                    r_d.stop  = 1'b0;
                end
            end

            ST_ISSUE: begin
                r_d.st   = ST_WAIT;
                r_d.stop = stop_req;
            end

            ST_WAIT: begin
                r_d.stop = stop_req;
                if (conv_done_i) begin
                    wr_en_o = 1'b1;
                    r_d.cnt = cnt_next;
                    case (r_q.mode)
                        MODE_CONT: begin
                            wr_addr_o = r_q.ptr;
                            if (r_q.split) set_flag = (r_q.ptr & GRP_MASK) == GRP_MASK;
                            else           set_flag = r_q.ptr == LAST_PTR;
                            r_d.ptr = r_q.ptr + CW'(1);
                            r_d.st  = stop_req ? ST_IDLE : ST_ISSUE;
                        end
                        MODE_SCAN: begin
                            r_d.rem = rem_clear;
                            if (r_q.split && cnt_next == GRP_CNT) set_flag = 1'b1;
                            if (pick_any_i) begin
                                r_d.chan = pick_idx_i;
                                r_d.st   = ST_ISSUE;
                            end else begin
                                set_flag = 1'b1;
                                r_d.st   = ST_IDLE;
                            end
                        end
                        default: begin
                            set_flag = 1'b1;
                            r_d.st   = ST_IDLE;
                        end
                    endcase
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (set_flag)       r_d.flag = 1'b1;
        else if (irq_clr_i) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign conv_start_o = r_q.st == ST_ISSUE;
    assign conv_chan_o  = r_q.chan;
    assign busy_o       = r_q.st != ST_IDLE;
    assign flag_o       = r_q.flag;

    // R11: the start pulse lasts one cycle
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R11: no converter start while idle
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !conv_start_o);

    // R9: a start while busy leaves the running mode untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(r_q.mode));

    // R10: a clear with no write pending empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !wr_en_o) |=> !flag_o);

    // R8: an empty scan mask is not accepted
    a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && mode_i == 2'd2 && mask_i == '0) |=> !busy_o);

    // R2: a store ends a single-mode sequence at the same edge
    a_r2_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && r_q.mode == MODE_SINGLE) |=> (!busy_o && flag_o));

endmodule

// File: rtl/adc_mode_sequencer.sv
module adc_mode_sequencer #(
    parameter int NCH      = 8,
    parameter int DW       = 8,
    parameter int SPLIT_AT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic [1:0]             mode_i,
    input  logic [$clog2(NCH)-1:0] chan_i,
    input  logic [NCH-1:0]         scan_mask_i,
    input  logic                   split_i,
    input  logic                   irq_en_i,
    input  logic                   irq_clr_i,
    output logic                   conv_start_o,
    output logic [$clog2(NCH)-1:0] conv_chan_o,
    input  logic                   conv_done_i,
    input  logic [DW-1:0]          conv_data_i,
    input  logic [$clog2(NCH)-1:0] rd_addr_i,
    output logic [DW-1:0]          rd_data_o,
    output logic                   busy_o,
    output logic                   irq_flag_o,
    output logic                   irq_o
);
    localparam int CW = $clog2(NCH);

    logic [NCH-1:0] pick_src;
    logic           pick_any;
    logic [CW-1:0]  pick_idx;
    logic           wr_en;
    logic [CW-1:0]  wr_addr;

    adc_seq_pick #(.NCH(NCH)) u_pick (
        .src_i (pick_src),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    adc_seq_ctrl #(.NCH(NCH), .SPLIT_AT(SPLIT_AT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .mode_i       (mode_i),
        .chan_i       (chan_i),
        .mask_i       (scan_mask_i),
        .split_i      (split_i),
        .irq_clr_i    (irq_clr_i),
        .conv_done_i  (conv_done_i),
        .pick_any_i   (pick_any),
        .pick_idx_i   (pick_idx),
        .pick_src_o   (pick_src),
        .conv_start_o (conv_start_o),
        .conv_chan_o  (conv_chan_o),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .busy_o       (busy_o),
        .flag_o       (irq_flag_o)
    );

    adc_seq_resbank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (conv_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = irq_flag_o & irq_en_i;

endmodule

// File: tb/tb_adc_mode_sequencer.sv
module tb_adc_mode_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [2:0] chan_i = '0;
    logic [7:0] scan_mask_i = '0;
    logic       split_i = 1'b0, irq_en_i = 1'b0, irq_clr_i = 1'b0;
    logic       conv_start_o;
    logic [2:0] conv_chan_o;
    logic       conv_done_i = 1'b0;
    logic [7:0] conv_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       busy_o, irq_flag_o, irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_mode_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .mode_i(mode_i), .chan_i(chan_i), .scan_mask_i(scan_mask_i),
        .split_i(split_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lowest(bit [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    // converter stub: latency of 2..4 cycles after the start pulse is seen
    int cd = 0, seq = 0;
    int stub_ch = 0;
    always @(negedge clk) begin
        conv_done_i = 1'b0;
        if (conv_start_o) begin
            cd = 2 + (seq % 3);
            stub_ch = conv_chan_o;
        end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                conv_done_i = 1'b1;
                conv_data_i = 8'((seq * 29 + stub_ch * 3 + 7) & 255);
                seq++;
            end
        end
    end

    // behavioural reference model
    bit       m_busy, m_issue, m_split, m_stop, m_flag;
    int       m_mode, m_cur, m_ptr, m_cnt;
    bit [7:0] m_rem;
    int       m_res [8];

    always @(posedge clk) begin
        bit fs, ok;
        if (!rst_n) begin
            m_busy = 0; m_issue = 0; m_split = 0; m_stop = 0; m_flag = 0;
            m_mode = 0; m_cur = 0; m_ptr = 0; m_cnt = 0; m_rem = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            fs = 0;
            if (!m_busy) begin
                if (start_i) begin
                    ok = 0;
                    if (mode_i == 0 || mode_i == 1) begin ok = 1; m_cur = chan_i; end
                    else if (mode_i == 2 && scan_mask_i != 0) begin
                        ok = 1; m_rem = scan_mask_i; m_cur = lowest(scan_mask_i);
                    end
                    if (ok) begin
                        m_busy = 1; m_mode = mode_i; m_split = split_i;
                        m_ptr = 0; m_cnt = 0; m_stop = 0; m_issue = 1;
                    end
                end
            end else begin
                if (stop_i && m_mode == 1) m_stop = 1;
                if (m_issue) m_issue = 0;
                else if (conv_done_i) begin
                    m_cnt++;
                    if (m_mode == 0) begin
                        m_res[m_cur] = conv_data_i; fs = 1; m_busy = 0;
                    end else if (m_mode == 1) begin
                        m_res[m_ptr] = conv_data_i;
                        if (m_split ? (m_ptr % 4 == 3) : (m_ptr == 7)) fs = 1;
                        m_ptr = (m_ptr + 1) % 8;
                        if (m_stop) m_busy = 0; else m_issue = 1;
                    end else begin
                        m_res[m_cur] = conv_data_i;
                        m_rem[m_cur] = 1'b0;
                        if (m_split && m_cnt == 4) fs = 1;
                        if (m_rem == 0) begin fs = 1; m_busy = 0; end
                        else begin m_cur = lowest(m_rem); m_issue = 1; end
                    end
                end
            end
            if (fs) m_flag = 1;
            else if (irq_clr_i) m_flag = 0;
        end
    end

    // per-cycle comparison, event logging and automatic flag clearing
    bit auto_clr = 0;
    bit flag_prev = 0;
    int total_starts = 0, total_rises = 0;
    int chan_log [4096];

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 busy", busy_o, m_busy);
            chk("R10 flag", irq_flag_o, m_flag);
            chk("R10 irq_o", irq_o, m_flag & irq_en_i);
            chk("R11 conv_start", conv_start_o, m_issue);
            if (m_issue) chk("R6 conv_chan", conv_chan_o, m_cur);
            chk("R3 R6 result", rd_data_o, m_res[rd_addr_i]);
            if (conv_start_o) begin
                if (total_starts < 4096) chan_log[total_starts] = conv_chan_o;
                total_starts++;
            end
            if (irq_flag_o && !flag_prev) total_rises++;
            flag_prev = irq_flag_o;
            irq_clr_i <= auto_clr && irq_flag_o;
            rd_addr_i <= rd_addr_i + 3'd1;
        end
    end

    task automatic launch(int md, int ch, bit [7:0] msk, bit spl);
        @(negedge clk);
        mode_i = 2'(md); chan_i = 3'(ch); scan_mask_i = msk; split_i = spl;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bs, br;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 flag", irq_flag_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 conv_start", conv_start_o, 0);
        repeat (8) @(negedge clk);  // result port sweeps all registers at 0

        auto_clr = 1; irq_en_i = 1;

        // R2 single conversion on channel 5
        bs = total_starts; br = total_rises;
        launch(0, 5, 8'h00, 0);
        wait_idle();
        chk("R2 start count", total_starts - bs, 1);
        chk("R2 channel", chan_log[bs], 5);
        chk("R2 flag count", total_rises - br, 1);

        // R9 start while busy is ignored; R5 stop ignored in single mode
        bs = total_starts;
        launch(0, 2, 8'h00, 0);
        mode_i = 2'd1; chan_i = 3'd6; start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        wait_idle();
        chk("R9 start count", total_starts - bs, 1);
        chk("R5 single completes", chan_log[bs], 2);

        // R4 R5 continuous, groups of four, stop after the 10th start
        bs = total_starts; br = total_rises;
        launch(1, 3, 8'h00, 1);
        while (total_starts - bs < 10) @(posedge clk);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        wait_idle();
        chk("R5 conversions", total_starts - bs, 10);
        chk("R4 split flags", total_rises - br, 2);

        // R3 R4 continuous, groups of eight, 17 conversions (wraps twice)
        bs = total_starts; br = total_rises;
        irq_en_i = 0;
        launch(1, 7, 8'h00, 0);
        while (total_starts - bs < 17) @(posedge clk);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        wait_idle();
        chk("R3 conversions", total_starts - bs, 17);
        chk("R4 eight flags", total_rises - br, 2);
        irq_en_i = 1;

        // R6 R7 scan of five channels with split
        bs = total_starts; br = total_rises;
        launch(2, 0, 8'b1011_0110, 1);
        wait_idle();
        chk("R6 scan count", total_starts - bs, 5);
        begin
            int k = 0;
            for (int i = 0; i < 8; i++) begin
                if (i == 1 || i == 2 || i == 4 || i == 5 || i == 7) begin
                    chk("R6 scan order", chan_log[bs + k], i);
                    k++;
                end
            end
        end
        chk("R7 split flags", total_rises - br, 2);

        // R7 two channels with split: one flag
        bs = total_starts; br = total_rises;
        launch(2, 0, 8'b0101_0000, 1);
        wait_idle();
        chk("R7 small scan count", total_starts - bs, 2);
        chk("R7 small scan flags", total_rises - br, 1);

        // R7 six channels without split: one flag
        bs = total_starts; br = total_rises;
        launch(2, 0, 8'b1111_1100, 0);
        wait_idle();
        chk("R7 full scan count", total_starts - bs, 6);
        chk("R7 no-split flags", total_rises - br, 1);

        // R2 one-bit scan mask acts as a single conversion
        bs = total_starts; br = total_rises;
        launch(2, 0, 8'b0000_1000, 1);
        wait_idle();
        chk("R2 one-bit scan channel", chan_log[bs], 3);
        chk("R2 one-bit scan flags", total_rises - br, 1);

        // R8 empty mask and reserved mode start nothing
        bs = total_starts;
        launch(2, 0, 8'h00, 0);
        chk("R8 empty mask busy", busy_o, 0);
        launch(3, 4, 8'hFF, 0);
        chk("R8 reserved busy", busy_o, 0);
        wait_idle();
        chk("R8 start count", total_starts - bs, 0);

        // R10 flag sticks with auto-clear off, then clears
        auto_clr = 0; irq_en_i = 0;
        launch(0, 1, 8'h00, 0);
        wait_idle();
        chk("R10 sticky flag", irq_flag_o, 1);
        chk("R10 gated irq", irq_o, 0);
        irq_en_i = 1;
        @(negedge clk);
        chk("R10 enabled irq", irq_o, 1);
        auto_clr = 1;
        repeat (3) @(negedge clk);
        chk("R10 cleared flag", irq_flag_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule